// File: doc/BRIEF.md
# SPI Master Burst Engine

This block is the data path of a byte-wide SPI master. Software loads outgoing bytes into a transmit queue. It then programs two lengths: the total number of bytes to clock on the bus, and how many of those bytes come from the queue. Setting a start bit runs the burst. Once the queued share is used up, the engine sends zero bytes for the rest of the burst. Each byte captured from the slave goes into a receive queue, unless software has asked for received data to be thrown away.

Clock polarity, clock phase and bit order are selected by control bits. The serial clock advances only on cycles flagged by an external rate enable, so the baud divider lives outside this block. If the transmit queue runs dry while queued bytes are still owed, the engine holds the serial clock at its idle level until data arrives. When the burst ends, a sticky completion flag is raised and the start bit drops. An interrupt line follows that flag when it is enabled.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, both queue levels read 0, the completion flag and `irq` are 0, `sclk` and `mosi` are 0, and control, enable and length registers are 0.
- R2: Register word address 6 returns the receive level in bits 6:0 and the transmit level in bits 22:16. Each queue holds 64 bytes. A byte pushed into a full queue is dropped.
- R3: Writing control (address 1) with bit 10 set while idle starts a burst. The burst produces exactly 8 leading `sclk` edges per burst byte. Each byte goes out most significant bit first, or least significant bit first when control bit 6 is 1.
- R4: Control bit 3 sets the idle level of `sclk`. With control bit 2 at 0, data is sampled on leading edges; with it at 1, data is sampled on trailing edges. `miso` is captured on the same edge on which `mosi` is valid for the slave.
- R5: The first N bytes of a burst are taken from the transmit queue in order, where N is the transmit length (address 5). The remaining bytes up to the burst length (address 4) are 0x00.
- R6: While queued bytes are still owed and the transmit queue is empty, `sclk` stays at its idle level and no edge occurs. Shifting resumes once a byte is written.
- R7: `sclk` changes during a burst only on a clock edge at which `sclk_tick` was 1.
- R8: With control bit 15 set, received bytes are not written into the receive queue. Otherwise each received byte is pushed, in order.
- R9: The completion flag (address 3, bit 16) is set, and control bit 10 reads 0, from the clock edge on which the final bit phase ends. At that edge `sclk` is back at its idle level.
- R10: `irq` equals completion flag AND enable bit 16 (address 2). Writing 1 to status bit 16 clears the flag; writing 0 leaves it unchanged.
- R11: Writing control bit 8 empties the transmit queue and bit 9 empties the receive queue. Both bits read back 0.
- R12: A burst length of 0 completes without any `sclk` edge.
- R13: Writing address 0 pushes `reg_wdata[7:0]` into the transmit queue. Reading address 0 returns the oldest received byte in bits 7:0 and removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 0) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| sclk_tick | input | 1 | Serial clock phase enable from external divider |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Completion interrupt |

## Verification
Register writes take effect at the next clock edge, and read data is valid in the same cycle as the address. The bench therefore samples `reg_rdata` a fraction of a period after it drives the address, before the edge that performs any pop. Serial-line effects come one clock edge after a `sclk_tick` cycle. A bus monitor running on the falling clock edge compares each `sclk` change against the tick seen at the preceding rising edge, and it takes `mosi` from the half-phase before the edge. The completion flag is due on the same edge as the final `sclk` return. The first falling edge on which `irq` is seen is where the bench checks that the full bit count has already been seen and that `sclk` is idle.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_LOAD, ENG_SHIFT} eng_state_e;

  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_CTRL  = 3'd1;
  localparam logic [2:0] A_IEN   = 3'd2;
  localparam logic [2:0] A_ISTAT = 3'd3;
  localparam logic [2:0] A_BURST = 3'd4;
  localparam logic [2:0] A_TXLEN = 3'd5;
  localparam logic [2:0] A_LEVEL = 3'd6;

  localparam int B_CPHA    = 2;
  localparam int B_CPOL    = 3;
  localparam int B_LSB     = 6;
  localparam int B_TXFLUSH = 8;
  localparam int B_RXFLUSH = 9;
  localparam int B_GO      = 10;
  localparam int B_DROP    = 15;
  localparam int B_DONE    = 16;
  localparam int B_TXLVL   = 16;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, wptr_d, rptr, rptr_d;
  logic [LW-1:0] level_d;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign pop_data = mem[rptr];

  always_comb begin
    wptr_d  = wptr;
    rptr_d  = rptr;
    level_d = level;
    if (flush) begin
      wptr_d  = '0;
      rptr_d  = '0;
      level_d = '0;
    end else begin
      if (do_push) wptr_d = wptr + AW'(1);
      if (do_pop)  rptr_d = rptr + AW'(1);
      level_d = level + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      wptr  <= wptr_d;
      rptr  <= rptr_d;
      level <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= push_data;
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (level == $past(level)));
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] tx_len,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             lsb_first,
  input  logic             drop_rx,
  input  logic             sclk_tick,
  input  logic             tx_empty,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [7:0]       rx_data,
  output logic             done,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  eng_state_e       st, st_d;
  logic [3:0]       ph, ph_d, ph_m1;
  logic [CNT_W-1:0] left, left_d, owed, owed_d;
  logic [7:0]       txb, txb_d, rxb, rxb_d, rxb_n;
  logic [2:0]       oidx, obit, sbit;
  logic             shifting, sample;

  assign shifting = (st == ENG_SHIFT);
  assign busy     = (st != ENG_IDLE);
  assign ph_m1    = ph - 4'd1;
  assign oidx     = cpha ? ((ph == 4'd0) ? 3'd0 : ph_m1[3:1]) : ph[3:1];
  assign obit     = lsb_first ? oidx : 3'd7 - oidx;
  assign sbit     = lsb_first ? ph[3:1] : 3'd7 - ph[3:1];
  assign sample   = shifting && sclk_tick && (ph[0] == cpha);
  assign sclk     = shifting ? (cpol ^ ph[0]) : cpol;
  assign mosi     = shifting ? txb[obit] : 1'b0;
  assign rx_data  = rxb_n;

  always_comb begin
    rxb_n = rxb;
    if (sample) rxb_n[sbit] = miso;
  end

  always_comb begin
    st_d    = st;
    ph_d    = ph;
    left_d  = left;
    owed_d  = owed;
    txb_d   = txb;
    rxb_d   = rxb;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    done    = 1'b0;
    unique case (st)
      ENG_IDLE: if (start) begin
        left_d = burst_len;
        owed_d = tx_len;
        st_d   = ENG_LOAD;
      end
      ENG_LOAD: begin
        if (left == '0) begin
          done = 1'b1;
          st_d = ENG_IDLE;
        end else if (owed != '0) begin
          if (!tx_empty) begin
            tx_pop = 1'b1;
            txb_d  = tx_data;
            owed_d = owed - CNT_W'(1);
            ph_d   = 4'd0;
            rxb_d  = 8'h00;
            st_d   = ENG_SHIFT;
          end
        end else begin
          txb_d = 8'h00;
          ph_d  = 4'd0;
          rxb_d = 8'h00;
          st_d  = ENG_SHIFT;
        end
      end
      ENG_SHIFT: begin
        rxb_d = rxb_n;
        if (sclk_tick) begin
          ph_d = ph + 4'd1;
          if (ph == 4'd15) begin
            left_d  = left - CNT_W'(1);
            rx_push = !drop_rx;
            if (left == CNT_W'(1)) begin
              done = 1'b1;
              st_d = ENG_IDLE;
            end else begin
              st_d = ENG_LOAD;
            end
          end
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ENG_IDLE;
      ph   <= '0;
      left <= '0;
      owed <= '0;
      txb  <= '0;
      rxb  <= '0;
    end else begin
      st   <= st_d;
      ph   <= ph_d;
      left <= left_d;
      owed <= owed_d;
      txb  <= txb_d;
      rxb  <= rxb_d;
    end
  end

  // R7: serial clock moves only after a phase enable
  p_sclk_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(cpol) && !$stable(sclk)) |-> $past(sclk_tick));
  p_stall_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ENG_LOAD && left != '0 && owed != '0 && tx_empty) |=>
    (st == ENG_LOAD && sclk == cpol));
  p_pop_in_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (owed != '0 && !tx_empty));
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 24,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        sclk_tick,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);
  logic             cpha_q, cpol_q, lsb_q, drop_q, go_q, ien_q, done_flag_q;
  logic             cpha_d, cpol_d, lsb_d, drop_d, go_d, ien_d, done_flag_d;
  logic [CNT_W-1:0] burst_q, burst_d, txlen_q, txlen_d;
  logic             wr_ctrl, start, tx_flush, rx_flush, tx_push, rx_pop;
  logic             tx_pop, rx_push, done, busy, tx_empty;
  logic [7:0]       tx_head, rx_head, rx_byte;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic             unused_bits;

  assign unused_bits = ^{reg_wdata, busy};
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign start    = wr_ctrl && reg_wdata[B_GO] && !go_q;
  assign tx_flush = wr_ctrl && reg_wdata[B_TXFLUSH];
  assign rx_flush = wr_ctrl && reg_wdata[B_RXFLUSH];
  assign tx_push  = reg_wr && (reg_addr == A_DATA);
  assign rx_pop   = reg_rd && (reg_addr == A_DATA);
  assign irq      = done_flag_q && ien_q;

  always_comb begin
    cpha_d = cpha_q; cpol_d = cpol_q; lsb_d = lsb_q; drop_d = drop_q;
    go_d = go_q; ien_d = ien_q; done_flag_d = done_flag_q;
    burst_d = burst_q; txlen_d = txlen_q;
    if (wr_ctrl) begin
      cpha_d = reg_wdata[B_CPHA];
      cpol_d = reg_wdata[B_CPOL];
      lsb_d  = reg_wdata[B_LSB];
      drop_d = reg_wdata[B_DROP];
    end
    if (start) go_d = 1'b1;
    if (done)  go_d = 1'b0;
    if (reg_wr && reg_addr == A_IEN)   ien_d = reg_wdata[B_DONE];
    if (reg_wr && reg_addr == A_BURST) burst_d = reg_wdata[CNT_W-1:0];
    if (reg_wr && reg_addr == A_TXLEN) txlen_d = reg_wdata[CNT_W-1:0];
    if (reg_wr && reg_addr == A_ISTAT && reg_wdata[B_DONE]) done_flag_d = 1'b0;
    if (done) done_flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpha_q <= 1'b0; cpol_q <= 1'b0; lsb_q <= 1'b0; drop_q <= 1'b0;
      go_q <= 1'b0; ien_q <= 1'b0; done_flag_q <= 1'b0;
      burst_q <= '0; txlen_q <= '0;
    end else begin
      cpha_q <= cpha_d; cpol_q <= cpol_d; lsb_q <= lsb_d; drop_q <= drop_d;
      go_q <= go_d; ien_q <= ien_d; done_flag_q <= done_flag_d;
      burst_q <= burst_d; txlen_q <= txlen_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_DATA:  reg_rdata[7:0] = rx_head;
      A_CTRL: begin
        reg_rdata[B_CPHA] = cpha_q;
        reg_rdata[B_CPOL] = cpol_q;
        reg_rdata[B_LSB]  = lsb_q;
        reg_rdata[B_GO]   = go_q;
        reg_rdata[B_DROP] = drop_q;
      end
      A_IEN:   reg_rdata[B_DONE] = ien_q;
      A_ISTAT: reg_rdata[B_DONE] = done_flag_q;
      A_BURST: reg_rdata[CNT_W-1:0] = burst_q;
      A_TXLEN: reg_rdata[CNT_W-1:0] = txlen_q;
      A_LEVEL: begin
        reg_rdata[LVL_W-1:0]        = rx_lvl;
        reg_rdata[B_TXLVL +: LVL_W] = tx_lvl;
      end
      default: reg_rdata = '0;
    endcase
  end

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_push), .push_data(reg_wdata[7:0]),
    .pop(tx_pop), .pop_data(tx_head),
    .level(tx_lvl), .empty(tx_empty), .full()
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .push_data(rx_byte),
    .pop(rx_pop), .pop_data(rx_head),
    .level(rx_lvl), .empty(), .full()
  );

  spi_shift_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start),
    .burst_len(burst_q), .tx_len(txlen_q),
    .cpol(cpol_q), .cpha(cpha_q), .lsb_first(lsb_q), .drop_rx(drop_q),
    .sclk_tick(sclk_tick), .tx_empty(tx_empty), .tx_data(tx_head),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_byte),
    .done(done), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  p_done_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(reg_wr && reg_addr == A_ISTAT)) |=> (done_flag_q && !go_q));
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q && done_flag_q));
  p_drop_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q && !tx_push) |=> (rx_lvl <= $past(rx_lvl)));
  p_idle_sclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_q && !busy) |-> (sclk == cpol_q));
endmodule

// File: tb/spi_burst_engine_tb.sv
module spi_burst_engine_tb;
  logic        clk, rst_n, reg_wr, reg_rd, sclk_tick, miso;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sclk, mosi, irq;

  spi_burst_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk_tick(sclk_tick), .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
  );

  assign miso = ~mosi;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    finish_run();
  end

  // phase enable every third cycle, and a serial-line monitor
  int   tick_cnt;
  logic prev_sclk, prev_mosi;
  logic mon_on, m_cpol, m_cpha, m_lsb;
  logic [7:0] mon_b [64];
  int   mon_bits, mon_edges, tick_viol;

  always @(negedge clk) begin
    if (!rst_n) begin
      tick_cnt = 0; sclk_tick = 1'b0;
    end else begin
      if (mon_on && sclk !== prev_sclk) begin
        mon_edges++;
        if (!sclk_tick) tick_viol++;
        if (((sclk != m_cpol) ? 1'b1 : 1'b0) == !m_cpha) begin
          if (mon_bits < 512)
            mon_b[mon_bits/8][m_lsb ? (mon_bits%8) : (7-(mon_bits%8))] = prev_mosi;
          mon_bits++;
        end
      end
      tick_cnt = (tick_cnt == 2) ? 0 : tick_cnt + 1;
      sclk_tick = (tick_cnt == 2);
    end
    prev_sclk = sclk;
    prev_mosi = mosi;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic mon_clear();
    @(posedge clk); #1;
    mon_bits = 0; mon_edges = 0; tick_viol = 0;
    for (int i = 0; i < 64; i++) mon_b[i] = 8'h00;
  endtask

  task automatic wait_irq(input int lim, output bit seen);
    seen = 0;
    for (int i = 0; i < lim && !seen; i++) begin
      @(negedge clk);
      #1 if (irq) seen = 1;
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  // {cpol,cpha,lsb}[31:29], drop[28], burst[27:20], txlen[19:12], seed[11:4]
  localparam logic [31:0] VEC [8] = '{
    {3'b000, 1'b0, 8'd4,  8'd4,  8'h11, 4'h0},
    {3'b001, 1'b0, 8'd3,  8'd3,  8'hA5, 4'h0},
    {3'b010, 1'b0, 8'd5,  8'd2,  8'h3C, 4'h0},
    {3'b011, 1'b1, 8'd2,  8'd2,  8'h81, 4'h0},
    {3'b100, 1'b0, 8'd4,  8'd0,  8'h00, 4'h0},
    {3'b110, 1'b0, 8'd6,  8'd6,  8'h5A, 4'h0},
    {3'b111, 1'b0, 8'd3,  8'd1,  8'hC3, 4'h0},
    {3'b101, 1'b0, 8'd64, 8'd64, 8'h07, 4'h0}
  };

  initial begin
    logic [31:0] v, ctl;
    bit seen;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    mon_on = 1'b0; m_cpol = 1'b0; m_cpha = 1'b0; m_lsb = 1'b0;
    mon_bits = 0; mon_edges = 0; tick_viol = 0;
    repeat (3) @(negedge clk);
    #1;
    check(sclk === 1'b0 && mosi === 1'b0 && irq === 1'b0, "R1 pins", {sclk, mosi, irq}, 0);
    @(negedge clk); rst_n = 1'b1;
    rd(3'd6, v); check(v === 0, "R1 levels", v, 0);
    rd(3'd3, v); check(v === 0, "R1 status", v, 0);
    rd(3'd1, v); check(v === 0, "R1 control", v, 0);

    // table of bursts: R3 R4 R5 R8 R9 R13
    for (int k = 0; k < 8; k++) begin
      logic [2:0] md; logic drop; int bl, tl; logic [7:0] sd;
      md = VEC[k][31:29]; drop = VEC[k][28]; bl = int'(VEC[k][27:20]);
      tl = int'(VEC[k][19:12]); sd = VEC[k][11:4];
      mon_on = 1'b0;
      ctl = (32'(md[2]) << 3) | (32'(md[1]) << 2) | (32'(md[0]) << 6) | (32'(drop) << 15);
      wr(3'd1, ctl | 32'h300);
      m_cpol = md[2]; m_cpha = md[1]; m_lsb = md[0];
      for (int i = 0; i < tl; i++) wr(3'd0, 32'(pat(sd, i)));
      wr(3'd4, 32'(bl)); wr(3'd5, 32'(tl));
      wr(3'd2, 32'h1_0000); wr(3'd3, 32'h1_0000);
      mon_clear();
      mon_on = 1'b1;
      wr(3'd1, ctl | 32'h400);
      wait_irq(20000, seen);
      check(seen && mon_bits == 8*bl, "R9 flag with last edge", mon_bits, 8*bl);
      check(sclk === m_cpol, "R4 idle level", sclk, m_cpol);
      check(mon_edges == 16*bl && tick_viol == 0, "R7 edges on tick", mon_edges, 16*bl);
      rd(3'd1, v); check(v[10] === 1'b0, "R9 go cleared", v, ctl);
      for (int i = 0; i < bl; i++) begin
        logic [7:0] e;
        e = (i < tl) ? pat(sd, i) : 8'h00;
        check(mon_b[i] === e, "R5 R3 byte on mosi", mon_b[i], e);
      end
      rd(3'd6, v);
      check(v[6:0] == 7'((drop) ? 0 : bl), "R8 rx level", v, drop ? 0 : bl);
      if (!drop)
        for (int i = 0; i < bl; i++) begin
          logic [7:0] e;
          e = ~((i < tl) ? pat(sd, i) : 8'h00);
          rd(3'd0, v);
          check(v[7:0] === e, "R13 R4 rx byte", v, e);
        end
      wr(3'd3, 32'h1_0000);
    end

    // R6 stall
    mon_on = 1'b0;
    wr(3'd1, 32'h300); m_cpol = 0; m_cpha = 0; m_lsb = 0;
    wr(3'd0, 32'h9C);
    wr(3'd4, 2); wr(3'd5, 2);
    mon_clear(); mon_on = 1'b1;
    wr(3'd1, 32'h400);
    repeat (200) @(negedge clk);
    #1 check(mon_edges == 16 && sclk === 1'b0 && !irq, "R6 stall", mon_edges, 16);
    wr(3'd0, 32'h63);
    wait_irq(2000, seen);
    check(seen && mon_b[1] === 8'h63 && mon_b[0] === 8'h9C, "R6 resume", {mon_b[0], mon_b[1]}, 16'h9C63);

    // R10 write-one-to-clear and enable gating
    wr(3'd3, 32'h0); #1 check(irq === 1'b1, "R10 write 0 keeps", irq, 1);
    wr(3'd2, 32'h0); #1 check(irq === 1'b0, "R10 enable gates", irq, 0);
    rd(3'd3, v); check(v === 32'h1_0000, "R10 flag held", v, 32'h1_0000);
    wr(3'd3, 32'h1_0000);
    rd(3'd3, v); check(v === 0, "R10 cleared", v, 0);

    // R11 receive flush
    rd(3'd6, v); check(v[6:0] == 2, "R11 rx before", v, 2);
    wr(3'd1, 32'h200);
    rd(3'd6, v); check(v === 0, "R11 rx flushed", v, 0);
    rd(3'd1, v); check(v[9:8] === 2'b00, "R11 bits read 0", v, 0);

    // R2 overflow and R11 transmit flush
    for (int i = 0; i < 66; i++) wr(3'd0, 32'(i));
    rd(3'd6, v); check(v === (32'd64 << 16), "R2 tx full level", v, 32'd64 << 16);
    wr(3'd1, 32'h100);
    rd(3'd6, v); check(v === 0, "R11 tx flushed", v, 0);

    // R12 zero-length burst
    wr(3'd2, 32'h1_0000); wr(3'd4, 0); wr(3'd5, 0);
    mon_clear(); mon_on = 1'b1;
    wr(3'd1, 32'h400);
    wait_irq(50, seen);
    check(seen && mon_edges == 0, "R12 empty burst", mon_edges, 0);

    finish_run();
  end
endmodule